// File: doc/BRIEF.md
# Dual-Mode Pulse Accumulator Counter

This block is an 8-bit accumulator fed by one external pulse pin. It has two ways of counting. In event mode it adds one for each edge of the pin of the polarity chosen by software, which makes it a simple external event counter. In gated mode it adds one on every 64th system-clock cycle for as long as the pin sits at its active level, so the count measures how long the pin has been active.

One control bit, called the level-select bit here, serves both modes. In event mode it picks the counted edge. In gated mode it picks the pin level that blocks counting. The pin passes through a two-flop synchronizer, and edges are found by comparing the synchronized sample with the one before it.

A small register port gives software access to the control bits, the count and two sticky flags. The overflow flag is set when the count wraps. The edge flag is set on the selected pin edge. Both flags are cleared by writing 1 to them. A write to the count loads it directly and wins over any increment in the same cycle.

Top module: `pulse_accum`

## Requirements
- R1: After synchronous reset the control register, the count and both flags read as 0.
- R2: While the enable bit (control bit 6) is 0 the count holds its value whatever the pin does, except when software writes the count.
- R3: In event mode (control bit 5 = 0) with level-select (control bit 4) = 0, each falling edge of the pin adds one to the count, and rising edges are ignored. With level-select = 1, each rising edge adds one and falling edges are ignored. The count reflects an edge no later than the third clock edge after the pin changes.
- R4: In gated mode (control bit 5 = 1) the count adds one on each tick of a free-running divide-by-64 prescaler that starts at reset, for as long as the pin is not inhibited. Any 640 consecutive clock cycles of uninhibited gating therefore add exactly 10, and 16384 cycles take the count all the way round back to its starting value.
- R5: In gated mode a low pin inhibits counting when level-select = 0, and a high pin inhibits counting when level-select = 1.
- R6: When an increment takes the count from 0xFF to 0x00, the overflow flag (address 2, bit 7) is set. It stays set until a write to address 2 with bit 7 = 1.
- R7: While enabled, the edge flag (address 2, bit 6) is set on the selected edge. In event mode this is the counted edge. In gated mode it is the edge that ends the active level: falling for level-select = 0, rising for level-select = 1. A write to address 2 with bit 6 = 1 clears it.
- R8: A write to address 1 loads the count with the write data on that clock edge. It takes priority over an increment in the same cycle.
- R9: Register map: address 0 is control, with only bits 6, 5 and 4 writable and all other bits reading 0. Address 1 is the count. Address 2 holds the flags in bits 7 and 6, with all other bits reading 0. Address 3 reads 0. Reads are combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| pulse_in | input | 1 | Asynchronous external pulse pin |
| reg_addr | input | 2 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr |
| ovf_flag | output | 1 | Sticky overflow flag |
| edge_flag | output | 1 | Sticky selected-edge flag |

## Verification
The bound checker checks these rules on every cycle:
- the reset values;
- that a disabled or inhibited accumulator never moves;
- that gated counting only advances on a prescaler tick;
- that the count never steps by more than one unless it is written;
- that a count write always lands;
- that a wrap from 0xFF always raises the overflow flag.

Some behaviour can only be shown by the bench's scenarios, because it depends on the exact pin history and the prescaler phase:
- which edge polarity is counted;
- where the edge flag is raised in each mode;
- the exact 10-per-640-cycle rate;
- the full 16384-cycle wrap;
- the register readback layout.

// File: rtl/pa_pkg.sv
package pa_pkg;
    localparam int REG_AW = 2;
    localparam int REG_DW = 8;

    typedef enum logic [REG_AW-1:0] {
        ADDR_CTRL  = 2'd0,
        ADDR_COUNT = 2'd1,
        ADDR_FLAGS = 2'd2,
        ADDR_NONE  = 2'd3
    } pa_addr_e;

    // control bit positions
    localparam int CTRL_EN_BIT   = 6;
    localparam int CTRL_MODE_BIT = 5;
    localparam int CTRL_LVL_BIT  = 4;
    // flag bit positions
    localparam int FLAG_OVF_BIT  = 7;
    localparam int FLAG_EDGE_BIT = 6;

    typedef struct packed {
        logic enable;
        logic gated;
        logic lvl_sel;
    } pa_ctrl_t;
endpackage

// File: rtl/pa_sync_edge.sv
module pa_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    output logic level,
    output logic rise,
    output logic fall
);
    localparam int DEPTH = STAGES + 1;

    typedef struct packed {
        logic [DEPTH-1:0] shift;
    } sync_state_t;

    sync_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.shift = {st_q.shift[DEPTH-2:0], pin};
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    logic prev_lvl;
    assign level    = st_q.shift[STAGES-1];
    assign prev_lvl = st_q.shift[STAGES];
    assign rise     = level & ~prev_lvl;
    assign fall     = ~level & prev_lvl;
endmodule

// File: rtl/pa_prescaler.sv
module pa_prescaler #(
    parameter int DIV = 64
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int PW = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    typedef struct packed {
        logic [PW-1:0] phase;
    } pre_state_t;

    pre_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.phase == LAST) st_d.phase = '0;
        else                    st_d.phase = st_q.phase + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign tick = (st_q.phase == LAST);
endmodule

// File: rtl/pulse_accum.sv
module pulse_accum #(
    parameter int CNT_W       = 8,
    parameter int PRESCALE    = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       pulse_in,
    input  logic [1:0] reg_addr,
    input  logic       reg_wr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       ovf_flag,
    output logic       edge_flag
);
    import pa_pkg::*;

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        pa_ctrl_t         ctrl;
        logic [CNT_W-1:0] count;
        logic             ovf;
        logic             edgef;
    } acc_state_t;

    acc_state_t st_d, st_q;

    logic sync_lvl, pin_rise, pin_fall, tick;

    pa_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .pin   (pulse_in),
        .level (sync_lvl),
        .rise  (pin_rise),
        .fall  (pin_fall)
    );

    pa_prescaler #(.DIV(PRESCALE)) u_pre (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    logic wr_ctrl, wr_count, wr_flags;
    logic gate_open, sel_edge, do_inc;

    always_comb begin
        wr_ctrl  = reg_wr && (reg_addr == ADDR_CTRL);
        wr_count = reg_wr && (reg_addr == ADDR_COUNT);
        wr_flags = reg_wr && (reg_addr == ADDR_FLAGS);
        // the gate is open when the pin differs from the inhibiting level
        gate_open = sync_lvl ^ st_q.ctrl.lvl_sel;
        // the same edge serves both modes: counted edge or end of gate
        sel_edge  = st_q.ctrl.lvl_sel ? pin_rise : pin_fall;
        if (!st_q.ctrl.enable)   do_inc = 1'b0;
        else if (st_q.ctrl.gated) do_inc = tick && gate_open;
        else                      do_inc = sel_edge;
    end

    always_comb begin
        st_d = st_q;
        if (wr_ctrl) begin
            st_d.ctrl.enable  = reg_wdata[CTRL_EN_BIT];
            st_d.ctrl.gated   = reg_wdata[CTRL_MODE_BIT];
            st_d.ctrl.lvl_sel = reg_wdata[CTRL_LVL_BIT];
        end
        if (wr_count)    st_d.count = reg_wdata[CNT_W-1:0];
        else if (do_inc) st_d.count = st_q.count + 1'b1;

        if (wr_flags && reg_wdata[FLAG_OVF_BIT])  st_d.ovf = 1'b0;
        if (do_inc && !wr_count && st_q.count == CNT_MAX) st_d.ovf = 1'b1;

        if (wr_flags && reg_wdata[FLAG_EDGE_BIT]) st_d.edgef = 1'b0;
        if (st_q.ctrl.enable && sel_edge)          st_d.edgef = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADDR_CTRL: begin
                reg_rdata[CTRL_EN_BIT]   = st_q.ctrl.enable;
                reg_rdata[CTRL_MODE_BIT] = st_q.ctrl.gated;
                reg_rdata[CTRL_LVL_BIT]  = st_q.ctrl.lvl_sel;
            end
            ADDR_COUNT: reg_rdata[CNT_W-1:0] = st_q.count;
            ADDR_FLAGS: begin
                reg_rdata[FLAG_OVF_BIT]  = st_q.ovf;
                reg_rdata[FLAG_EDGE_BIT] = st_q.edgef;
            end
            default: reg_rdata = '0;
        endcase
    end

    assign ovf_flag  = st_q.ovf;
    assign edge_flag = st_q.edgef;

    // observation points for the bound checker
    logic [CNT_W-1:0] obs_count;
    logic obs_en, obs_gated, obs_lvl, obs_tick, obs_sync;
    assign obs_count = st_q.count;
    assign obs_en    = st_q.ctrl.enable;
    assign obs_gated = st_q.ctrl.gated;
    assign obs_lvl   = st_q.ctrl.lvl_sel;
    assign obs_tick  = tick;
    assign obs_sync  = sync_lvl;
endmodule

// File: rtl/pa_checker.sv
module pa_checker #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic [1:0]       reg_addr,
    input logic             reg_wr,
    input logic [7:0]       reg_wdata,
    input logic             ovf_flag,
    input logic             edge_flag,
    input logic [CNT_W-1:0] count,
    input logic             en,
    input logic             gated,
    input logic             lvl,
    input logic             tick,
    input logic             sync_lvl
);
    logic wr_cnt;
    assign wr_cnt = reg_wr && (reg_addr == 2'd1);

    p_reset_r1: assert property (@(posedge clk)
        rst |=> (count == '0 && !ovf_flag && !edge_flag && !en && !gated && !lvl));

    p_disabled_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (!en && !wr_cnt) |=> (count == $past(count)));

    p_gated_tick_only_r4: assert property (@(posedge clk) disable iff (rst)
        (en && gated && !tick && !wr_cnt) |=> $stable(count));

    p_inhibit_r5: assert property (@(posedge clk) disable iff (rst)
        (en && gated && (sync_lvl == lvl) && !wr_cnt) |=> $stable(count));

    p_single_step_r3: assert property (@(posedge clk) disable iff (rst)
        !wr_cnt |=> (count == $past(count) || count == $past(count) + 1'b1));

    p_wrap_sets_ovf_r6: assert property (@(posedge clk) disable iff (rst)
        (count == {CNT_W{1'b1}} && !wr_cnt) |=> (count != '0 || ovf_flag));

    p_write_load_r8: assert property (@(posedge clk) disable iff (rst)
        wr_cnt |=> (count == $past(reg_wdata[CNT_W-1:0])));
endmodule

bind pulse_accum pa_checker #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .ovf_flag  (ovf_flag),
    .edge_flag (edge_flag),
    .count     (obs_count),
    .en        (obs_en),
    .gated     (obs_gated),
    .lvl       (obs_lvl),
    .tick      (obs_tick),
    .sync_lvl  (obs_sync)
);

// File: tb/pulse_accum_test.sv
`timescale 1ns/1ps
module pulse_accum_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pulse_in = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       ovf_flag, edge_flag;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    pulse_accum uut (
        .clk(clk), .rst(rst), .pulse_in(pulse_in),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .ovf_flag(ovf_flag), .edge_flag(edge_flag)
    );

    task automatic check(input string req, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%02h expected=%02h", req, what, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #0.5;
        d = reg_rdata;
    endtask

    task automatic set_pin(input logic v);
        @(negedge clk);
        pulse_in = v;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset;
        logic [7:0] v;
        reg_read(2'd0, v); check("R1", "ctrl after reset", v, 8'h00);
        reg_read(2'd1, v); check("R1", "count after reset", v, 8'h00);
        reg_read(2'd2, v); check("R1", "flags after reset", v, 8'h00);
    endtask

    task automatic t_regmap;
        logic [7:0] v;
        reg_write(2'd0, 8'hFF);
        reg_read(2'd0, v); check("R9", "ctrl readback mask", v, 8'h70);
        reg_write(2'd0, 8'h00);
        reg_write(2'd3, 8'hFF);
        reg_read(2'd3, v); check("R9", "address 3 reads zero", v, 8'h00);
        reg_write(2'd1, 8'hA5);
        reg_read(2'd1, v); check("R8", "count load", v, 8'hA5);
    endtask

    task automatic t_hold;
        logic [7:0] v;
        reg_write(2'd1, 8'h33);
        for (int i = 0; i < 3; i++) begin
            set_pin(1'b1);
            set_pin(1'b0);
        end
        reg_read(2'd1, v); check("R2", "count held while disabled", v, 8'h33);
        reg_read(2'd2, v); check("R2", "no flags while disabled", v, 8'h00);
    endtask

    task automatic t_event_fall;
        logic [7:0] v;
        reg_write(2'd1, 8'h00);
        reg_write(2'd0, 8'h40);
        set_pin(1'b1);
        reg_read(2'd1, v); check("R3", "rise ignored with level-select 0", v, 8'h00);
        reg_read(2'd2, v); check("R7", "no edge flag on rise", v, 8'h00);
        set_pin(1'b0);
        reg_read(2'd1, v); check("R3", "fall counted", v, 8'h01);
        reg_read(2'd2, v); check("R7", "edge flag on fall", v, 8'h40);
        reg_write(2'd2, 8'h40);
        reg_read(2'd2, v); check("R7", "edge flag cleared", v, 8'h00);
        reg_write(2'd0, 8'h00);
    endtask

    task automatic t_event_rise;
        logic [7:0] v;
        reg_write(2'd1, 8'h00);
        reg_write(2'd0, 8'h50);
        for (int i = 0; i < 3; i++) begin
            set_pin(1'b1);
            set_pin(1'b0);
        end
        reg_read(2'd1, v); check("R3", "three rises counted", v, 8'h03);
        reg_write(2'd0, 8'h00);
        reg_write(2'd2, 8'hC0);
    endtask

    task automatic t_overflow;
        logic [7:0] v;
        reg_write(2'd1, 8'hFE);
        reg_write(2'd0, 8'h50);
        set_pin(1'b1); set_pin(1'b0);
        reg_read(2'd2, v); check("R6", "no overflow at FF", v & 8'h80, 8'h00);
        set_pin(1'b1); set_pin(1'b0);
        reg_read(2'd1, v); check("R6", "count wrapped", v, 8'h00);
        reg_read(2'd2, v); check("R6", "overflow set", v & 8'h80, 8'h80);
        reg_write(2'd0, 8'h00);
        reg_write(2'd2, 8'h80);
        reg_read(2'd2, v); check("R6", "overflow cleared", v & 8'h80, 8'h00);
        reg_write(2'd2, 8'hC0);
    endtask

    // gated run: enable at the final write edge, then 640 counted edges
    task automatic gated_run(input logic [7:0] ctrl, output logic [7:0] v);
        reg_write(2'd1, 8'h00);
        @(negedge clk);
        reg_addr = 2'd0; reg_wdata = ctrl; reg_wr = 1'b1;
        @(posedge clk);
        #0.5 reg_wr = 1'b0;
        repeat (640) @(posedge clk);
        @(negedge clk);
        reg_addr = 2'd1;
        #0.5 v = reg_rdata;
        reg_write(2'd0, 8'h00);
    endtask

    task automatic t_gated;
        logic [7:0] v;
        set_pin(1'b1);
        gated_run(8'h60, v); check("R4", "640 cycles high gate gives 10", v, 8'd10);
        gated_run(8'h70, v); check("R5", "high pin inhibits with level-select 1", v, 8'd0);
        set_pin(1'b0);
        gated_run(8'h60, v); check("R5", "low pin inhibits with level-select 0", v, 8'd0);
        gated_run(8'h70, v); check("R4", "640 cycles low gate gives 10", v, 8'd10);
    endtask

    task automatic t_gate_edge;
        logic [7:0] v;
        reg_write(2'd2, 8'hC0);
        set_pin(1'b1);
        reg_write(2'd0, 8'h60);
        reg_read(2'd2, v); check("R7", "no flag while gate open", v, 8'h00);
        set_pin(1'b0);
        reg_read(2'd2, v); check("R7", "flag on gate trailing edge", v, 8'h40);
        reg_write(2'd0, 8'h00);
        reg_write(2'd2, 8'hC0);
    endtask

    task automatic t_wrap;
        logic [7:0] v;
        set_pin(1'b1);
        reg_write(2'd1, 8'h00);
        @(negedge clk);
        reg_addr = 2'd0; reg_wdata = 8'h60; reg_wr = 1'b1;
        @(posedge clk);
        #0.5 reg_wr = 1'b0;
        repeat (16384) @(posedge clk);
        @(negedge clk);
        reg_addr = 2'd1;
        #0.5 v = reg_rdata;
        check("R4", "full wrap returns to zero", v, 8'h00);
        check("R6", "full wrap sets overflow", {7'd0, ovf_flag}, 8'h01);
        reg_write(2'd0, 8'h00);
        reg_write(2'd2, 8'hC0);
    endtask

    // 64 back-to-back count writes while gated counting runs: one of them
    // lands on a prescaler tick, and the write must still win
    task automatic t_priority;
        int bad = 0;
        reg_write(2'd0, 8'h60);
        @(negedge clk);
        reg_addr = 2'd1; reg_wr = 1'b1; reg_wdata = 8'h80;
        for (int i = 0; i < 64; i++) begin
            @(negedge clk);
            #0.5;
            if (reg_rdata !== 8'(8'h80 + i)) begin
                bad++;
                $display("FAIL R8 write vs increment step %0d actual=%02h expected=%02h",
                         i, reg_rdata, 8'(8'h80 + i));
            end
            reg_wdata = 8'(8'h81 + i);
        end
        reg_wr = 1'b0;
        checks++;
        if (bad != 0) failures++;
        reg_write(2'd0, 8'h00);
    endtask

    initial begin
        #800000;
        failures++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_regmap();
        t_hold();
        t_event_fall();
        t_event_rise();
        t_overflow();
        t_gated();
        t_gate_edge();
        t_wrap();
        t_priority();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule